// File: doc/BRIEF.md
# Dual-Channel ADC Serial Frame Controller

This block is the host-side master for a two-channel, 12-bit sampling converter reached over a four-wire serial link. Each sample is one frame. Chip select falls, and a short setup interval passes with the serial clock held high. Then sixteen serial clock periods follow. During them the host sends the channel to convert next, and the converter returns the result of the current conversion. Chip select then rises and stays high for at least a minimum quiet interval, so that the converter can acquire the next input.

A frame starts on a one-cycle start pulse or continuously while the free-running input is high. A start pulse that arrives while a frame or its quiet interval is under way is held and served as soon as the pacing allows. A programmable period sets the smallest distance between successive chip-select falls, and the quiet minimum always applies on top of it. The captured 12-bit value, the channel-identifier bit returned with it, and a framing-error flag come out together with a one-cycle valid strobe.

The serial clock runs at the system clock divided by `2*SCLK_HALF`. The setup interval is `SETUP_CYC` system cycles and the quiet minimum is `QUIET_MIN` system cycles. One frame therefore keeps chip select low for `FRAME = SETUP_CYC + 32*SCLK_HALF` cycles.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, chip select and the serial clock are high, host data is 0 and the valid strobe is 0.
- R2: Chip select stays low for exactly FRAME cycles. For the first SETUP_CYC of them the serial clock is high. After that come 16 bit periods, each SCLK_HALF cycles low and then SCLK_HALF cycles high. The serial clock is high whenever chip select is high.
- R3: Host data carries the channel request during bit period 2 (counting from 0, the third bit) and is 0 at all other times. The request is taken in the cycle before chip select falls.
- R4: Converter data is sampled in the last low cycle of each bit period and shifted in MSB first. The result value is bits [11:0] of the 16-bit word.
- R5: The valid strobe is a one-cycle pulse exactly SETUP_CYC + 31*SCLK_HALF cycles after chip select falls. The result channel is bit 14 of the word.
- R6: The error flag is bit 15 of the word, which should be zero. It is high whenever that bit came in as 1.
- R7: Between two frames, chip select stays high for at least QUIET_MIN cycles.
- R8: While free-running, successive chip-select falls are exactly max(period setting, FRAME + QUIET_MIN) cycles apart.
- R9: A start pulse that comes during a frame is held and starts the next frame as early as R7 and R8 allow. Without a start pulse or free-running, no frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request for a single frame |
| free_run | input | 1 | Run frames back to back while high |
| chan_req | input | 1 | Channel to select for the next conversion |
| cfg_period | input | PERIOD_W | Minimum cycles from one chip-select fall to the next |
| adc_dout | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_sclk | output | 1 | Serial clock, high when idle |
| adc_din | output | 1 | Serial data to the converter |
| res_valid | output | 1 | One-cycle strobe for the result fields |
| res_data | output | 12 | Captured conversion value |
| res_chan | output | 1 | Channel-identifier bit returned with the value |
| res_err | output | 1 | Leading bit of the word was not zero |

## Verification
A bit-period counter that is off by one shows up within one serial clock period, as a misplaced serial clock edge or a channel bit in the wrong slot. A fault in the shift register shows up at the next valid strobe as a wrong value, channel or error flag. A pacing or pending-start fault shows up only when the next frame starts, as a chip-select fall at the wrong cycle. The reference model predicts every edge, so that fall is caught on the very cycle it is early or late.

// File: rtl/afc_pkg.sv
package afc_pkg;

    localparam int unsigned WORD_BITS = 16;
    localparam int unsigned DATA_BITS = 12;
    localparam int unsigned SEL_SLOT  = 2;
    localparam int unsigned ID_POS    = 14;
    localparam int unsigned LEAD_POS  = 15;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_SHIFT = 2'd2,
        PH_QUIET = 2'd3
    } afc_phase_e;

    typedef struct packed {
        logic                 err;
        logic                 chan;
        logic [DATA_BITS-1:0] data;
    } afc_result_t;

    function automatic int unsigned imax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic afc_result_t unpack_word(input logic [WORD_BITS-1:0] w);
        afc_result_t r;
        r.err  = w[LEAD_POS];
        r.chan = w[ID_POS];
        r.data = w[DATA_BITS-1:0];
        return r;
    endfunction

endpackage

// File: rtl/afc_pacer.sv
module afc_pacer
    import afc_pkg::*;
#(
    parameter int unsigned PERIOD_W  = 12,
    parameter int unsigned QUIET_MIN = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                free_run,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  afc_phase_e          phase,
    output logic                launch
);
    localparam int unsigned QW = $clog2(QUIET_MIN + 1);
    localparam logic [QW-1:0] QUIET_LAST = QW'(QUIET_MIN - 1);
    localparam logic [QW-1:0] QUIET_SAT  = QW'(QUIET_MIN);

    logic [PERIOD_W-1:0] since;
    logic [QW-1:0]       quiet;
    logic                pend;
    logic [PERIOD_W:0]   since_next;
    logic                gap_ok;
    logic                rate_ok;
    logic                allowed;
    logic                trig;

    always_comb begin
        since_next = {1'b0, since} + 1'b1;
        gap_ok     = (quiet >= QUIET_LAST);
        rate_ok    = (since_next >= {1'b0, cfg_period});
        allowed    = (phase == PH_IDLE) || ((phase == PH_QUIET) && gap_ok && rate_ok);
        trig       = start | free_run | pend;
        launch     = trig && allowed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            since <= '0;
            quiet <= '0;
            pend  <= 1'b0;
        end else begin
            pend <= (pend | start) & ~launch;
            if (launch) begin
                since <= '0;
            end else if (since != {PERIOD_W{1'b1}}) begin
                since <= since + 1'b1;
            end
            if (phase == PH_QUIET) begin
                if (quiet != QUIET_SAT) begin
                    quiet <= quiet + 1'b1;
                end
            end else begin
                quiet <= '0;
            end
        end
    end

endmodule

// File: rtl/afc_sequencer.sv
module afc_sequencer
    import afc_pkg::*;
#(
    parameter int unsigned SETUP_CYC = 2,
    parameter int unsigned SCLK_HALF = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       launch,
    input  logic       chan_req,
    output afc_phase_e phase,
    output logic       cs_n,
    output logic       sclk,
    output logic       din,
    output logic       sample_en,
    output logic       last_sample
);
    localparam int unsigned CW = $clog2(imax(SETUP_CYC, SCLK_HALF) + 1);
    localparam int unsigned BW = $clog2(WORD_BITS);
    localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] HALF_LAST  = CW'(SCLK_HALF - 1);
    localparam logic [BW-1:0] BIT_LAST   = BW'(WORD_BITS - 1);
    localparam logic [BW-1:0] SEL_IDX    = BW'(SEL_SLOT);

    logic [CW-1:0] cnt;
    logic          hi;
    logic [BW-1:0] bit_idx;
    logic          chan_q;
    logic          shifting;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            hi      <= 1'b0;
            bit_idx <= '0;
            chan_q  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE, PH_QUIET: begin
                    if (launch) begin
                        phase  <= PH_SETUP;
                        cnt    <= '0;
                        chan_q <= chan_req;
                    end
                end
                PH_SETUP: begin
                    if (cnt == SETUP_LAST) begin
                        phase   <= PH_SHIFT;
                        cnt     <= '0;
                        hi      <= 1'b0;
                        bit_idx <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_SHIFT: begin
                    if (cnt == HALF_LAST) begin
                        cnt <= '0;
                        if (!hi) begin
                            hi <= 1'b1;
                        end else begin
                            hi <= 1'b0;
                            if (bit_idx == BIT_LAST) begin
                                phase <= PH_QUIET;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        shifting    = (phase == PH_SHIFT);
        cs_n        = !((phase == PH_SETUP) || shifting);
        sclk        = !shifting || hi;
        din         = shifting && (bit_idx == SEL_IDX) && chan_q;
        sample_en   = shifting && !hi && (cnt == HALF_LAST);
        last_sample = sample_en && (bit_idx == BIT_LAST);
    end

endmodule

// File: rtl/afc_capture.sv
module afc_capture
    import afc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sample_en,
    input  logic        last_sample,
    input  logic        sdata,
    output logic        res_valid,
    output afc_result_t result
);
    logic [WORD_BITS-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= last_sample;
            if (sample_en) begin
                shreg <= {shreg[WORD_BITS-2:0], sdata};
            end
        end
    end

    assign result = unpack_word(shreg);

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import afc_pkg::*;
#(
    parameter int unsigned SCLK_HALF = 20,
    parameter int unsigned SETUP_CYC = 2,
    parameter int unsigned QUIET_MIN = 6,
    parameter int unsigned PERIOD_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 free_run,
    input  logic                 chan_req,
    input  logic [PERIOD_W-1:0]  cfg_period,
    input  logic                 adc_dout,
    output logic                 adc_cs_n,
    output logic                 adc_sclk,
    output logic                 adc_din,
    output logic                 res_valid,
    output logic [DATA_BITS-1:0] res_data,
    output logic                 res_chan,
    output logic                 res_err
);
    afc_phase_e  phase;
    logic        launch;
    logic        sample_en;
    logic        last_sample;
    afc_result_t result;

    afc_pacer #(
        .PERIOD_W (PERIOD_W),
        .QUIET_MIN(QUIET_MIN)
    ) u_pacer (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .free_run  (free_run),
        .cfg_period(cfg_period),
        .phase     (phase),
        .launch    (launch)
    );

    afc_sequencer #(
        .SETUP_CYC(SETUP_CYC),
        .SCLK_HALF(SCLK_HALF)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .chan_req   (chan_req),
        .phase      (phase),
        .cs_n       (adc_cs_n),
        .sclk       (adc_sclk),
        .din        (adc_din),
        .sample_en  (sample_en),
        .last_sample(last_sample)
    );

    afc_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .sample_en  (sample_en),
        .last_sample(last_sample),
        .sdata      (adc_dout),
        .res_valid  (res_valid),
        .result     (result)
    );

    assign res_data = result.data;
    assign res_chan = result.chan;
    assign res_err  = result.err;

endmodule

// File: rtl/afc_checker.sv
module afc_checker #(
    parameter int unsigned SETUP_CYC = 2,
    parameter int unsigned SCLK_HALF = 20,
    parameter int unsigned QUIET_MIN = 6
) (
    input logic clk,
    input logic rst,
    input logic adc_cs_n,
    input logic adc_sclk,
    input logic adc_din,
    input logic res_valid
);
    localparam int unsigned FRAME = SETUP_CYC + 32 * SCLK_HALF;

    int unsigned lo_cnt;
    int unsigned hi_cnt;
    logic        seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= 0;
            hi_cnt <= 0;
            seen   <= 1'b0;
        end else begin
            seen <= seen | ~adc_cs_n;
            if (adc_cs_n) begin
                lo_cnt <= 0;
                if (hi_cnt < QUIET_MIN + 1) hi_cnt <= hi_cnt + 1;
            end else begin
                hi_cnt <= 0;
                if (lo_cnt < FRAME + 1) lo_cnt <= lo_cnt + 1;
            end
        end
    end

    assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n |-> adc_sclk);

    assert_frame_len_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_cs_n) |-> (lo_cnt == FRAME));

    assert_din_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n |-> !adc_din);

    assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    assert_valid_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !adc_cs_n);

    assert_quiet_gap_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(adc_cs_n) && seen) |-> (hi_cnt >= QUIET_MIN));

endmodule

bind adc_frame_ctrl afc_checker #(
    .SETUP_CYC(SETUP_CYC),
    .SCLK_HALF(SCLK_HALF),
    .QUIET_MIN(QUIET_MIN)
) u_afc_chk (
    .clk      (clk),
    .rst      (rst),
    .adc_cs_n (adc_cs_n),
    .adc_sclk (adc_sclk),
    .adc_din  (adc_din),
    .res_valid(res_valid)
);

// File: tb/adc_frame_ctrl_tb.sv
`timescale 1ns/1ps
module adc_frame_ctrl_tb;
    localparam int HALF  = 2;
    localparam int SETUP = 2;
    localparam int QMIN  = 6;
    localparam int PW    = 10;
    localparam int FRAME = SETUP + 32 * HALF;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          free_run;
    logic          chan_req;
    logic [PW-1:0] cfg_period;
    logic          adc_dout = 1'b1;
    logic          adc_cs_n;
    logic          adc_sclk;
    logic          adc_din;
    logic          res_valid;
    logic [11:0]   res_data;
    logic          res_chan;
    logic          res_err;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    // reference model state
    int          m_t = 0;
    bit          m_ever = 0;
    bit          m_pend = 0;
    bit          m_chan = 0;
    int          m_frames = 0;
    int          err_frame = 1;
    logic [15:0] m_word = '0;

    // fall tracking
    bit prev_cs = 1'b1;
    int fall_cnt = 0;
    int last_fall = 0;
    int last_gap = 0;
    int hi_run = 0;

    always #2.5 clk = ~clk;

    adc_frame_ctrl #(
        .SCLK_HALF(HALF),
        .SETUP_CYC(SETUP),
        .QUIET_MIN(QMIN),
        .PERIOD_W (PW)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .free_run  (free_run),
        .chan_req  (chan_req),
        .cfg_period(cfg_period),
        .adc_dout  (adc_dout),
        .adc_cs_n  (adc_cs_n),
        .adc_sclk  (adc_sclk),
        .adc_din   (adc_din),
        .res_valid (res_valid),
        .res_data  (res_data),
        .res_chan  (res_chan),
        .res_err   (res_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // behavioural model: advances on each rising edge from the inputs held before it
    always @(posedge clk) begin
        bit trig;
        bit can;
        if (rst) begin
            m_ever = 0; m_t = 0; m_pend = 0; m_chan = 0; m_frames = 0;
        end else begin
            trig = free_run | start | m_pend;
            can  = !m_ever || ((m_t + 1 >= FRAME + QMIN) && (m_t + 1 >= int'(cfg_period)));
            if (trig && can) begin
                m_t    = 0;
                m_ever = 1;
                m_chan = chan_req;
                m_word = {1'(m_frames == err_frame), chan_req, 2'b10,
                          12'((m_frames * 613 + 91) % 4096)};
                m_frames++;
                m_pend = 0;
            end else begin
                if (m_ever) m_t++;
                m_pend = m_pend | start;
            end
        end
    end

    // per-cycle comparison and converter model, away from the rising edge
    always @(negedge clk) begin
        bit act;
        bit e_cs, e_sclk, e_din, e_val;
        int u, k;
        cyc++;
        act = m_ever && (m_t < FRAME);
        e_cs = !act; e_sclk = 1'b1; e_din = 1'b0;
        e_val = m_ever && (m_t == SETUP + 31 * HALF);
        k = -1;
        if (act && m_t >= SETUP) begin
            u = m_t - SETUP;
            k = u / (2 * HALF);
            e_sclk = ((u % (2 * HALF)) >= HALF);
            e_din = (k == 2) && m_chan;
        end
        if (!rst) begin
            chk(adc_cs_n == e_cs, "R2/R8 cs_n", adc_cs_n, e_cs);
            chk(adc_sclk == e_sclk, "R2 sclk", adc_sclk, e_sclk);
            chk(adc_din == e_din, "R3 din", adc_din, e_din);
            chk(res_valid == e_val, "R5 valid timing", res_valid, e_val);
            if (e_val) begin
                chk(res_data == m_word[11:0], "R4 res_data", res_data, m_word[11:0]);
                chk(res_chan == m_word[14], "R5 res_chan", res_chan, m_word[14]);
                chk(res_err == m_word[15], "R6 res_err", res_err, m_word[15]);
            end
            if (prev_cs && !adc_cs_n) begin
                if (fall_cnt > 0) begin
                    last_gap = cyc - last_fall;
                    chk(hi_run >= QMIN, "R7 quiet gap", hi_run, QMIN);
                end
                last_fall = cyc;
                fall_cnt++;
            end
            hi_run = adc_cs_n ? hi_run + 1 : 0;
            prev_cs = adc_cs_n;
        end
        adc_dout = (k >= 0) ? m_word[15 - k] : 1'b1;
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_falls(input int n);
        int target;
        target = fall_cnt + n;
        while (fall_cnt < target) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        finish_run();
    end

    initial begin
        int n0;
        rst = 1'b1; start = 1'b0; free_run = 1'b0; chan_req = 1'b0; cfg_period = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(adc_cs_n == 1'b1, "R1 cs_n in reset", adc_cs_n, 1);
        chk(adc_sclk == 1'b1, "R1 sclk in reset", adc_sclk, 1);
        chk(adc_din == 1'b0, "R1 din in reset", adc_din, 0);
        chk(res_valid == 1'b0, "R1 valid in reset", res_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(adc_cs_n == 1'b1 && res_valid == 1'b0, "R1 after reset", adc_cs_n, 1);

        // single frame on channel 1 (R2 R3 R4 R5)
        chan_req = 1'b1;
        pulse_start();
        chan_req = 1'b0;
        repeat (100) @(negedge clk);

        // channel 0 with a bad leading bit (R6)
        pulse_start();
        repeat (100) @(negedge clk);

        // start held during a frame (R9)
        chan_req = 1'b1;
        pulse_start();
        repeat (20) @(negedge clk);
        pulse_start();
        wait_falls(1);
        chk(last_gap == FRAME + QMIN, "R9 pending start gap", last_gap, FRAME + QMIN);
        repeat (100) @(negedge clk);

        // free-running with a long period (R8)
        cfg_period = PW'(150);
        free_run = 1'b1;
        wait_falls(2);
        chk(last_gap == 150, "R8 long period gap", last_gap, 150);
        chan_req = 1'b0;
        wait_falls(1);
        chk(last_gap == 150, "R8 long period gap 2", last_gap, 150);

        // free-running with a period shorter than a frame (R7 R8)
        cfg_period = PW'(20);
        wait_falls(2);
        chk(last_gap == FRAME + QMIN, "R8 short period gap", last_gap, FRAME + QMIN);
        free_run = 1'b0;
        repeat (100) @(negedge clk);

        // no trigger, no frame (R9)
        n0 = fall_cnt;
        repeat (300) @(negedge clk);
        chk(fall_cnt == n0, "R9 idle without trigger", fall_cnt, n0);

        finish_run();
    end

endmodule